// File: doc/BRIEF.md
# Seconds Real-Time Clock with Two Match Channels

The block keeps wall-clock time as a count of seconds. A 32-bit up-counter and a companion down-counter both move once for every one-second tick. Software normally loads them as a pair whose sum is all ones. Two match channels compare the up-counter against their own registers. Each channel latches a status bit that can raise the interrupt line, the wake line, or both. A force bit can also drive the wake line high on its own.

Software reaches every register through a plain 32-bit register bus. Writes are single-cycle. Reads are combinational and driven from the address. To load a new time safely, software sets the halt bit, writes both counters and then clears the halt bit. A 32-bit scratch key register is not affected by the software-reset control bit. Software can therefore store a known value there and tell a first power-up from a warm restart. Once a channel has fired, software writes all ones to its match register, which stops the channel from firing again.

Top module: `sec_rtc`

## Requirements
- R1: After the asynchronous reset, the up-counter (0x00), down-counter (0x04), control (0x10), status (0x14) and key (0x18) all read zero, both match registers (0x08, 0x0C) read 0xFFFFFFFF, and irq_o and wake_o are low.
- R2: When a clock edge samples tick_i high, control bit6 (halt) and bit4 (software reset) are clear and no bus write targets a counter, the up-counter increments and the down-counter decrements, each wrapping modulo 2^32.
- R3: While control bit6 is set, ticks leave both counters unchanged.
- R4: A bus write to 0x00 or 0x04 loads that counter at the next clock edge, whatever tick_i is doing. The counter that is not written still follows the tick.
- R5: While control bit4 is set, both counters are held at zero and bus writes to them have no effect. The key register keeps its value.
- R6: Status bit0 (channel 0, match register 0x08) and status bit1 (channel 1, 0x0C) become set one clock after the up-counter equals that channel's match value. They stay set while the values are equal, even if a clear is written at the same time.
- R7: Writing 1 to a bit of the status register (0x14) clears that bit. Writing 0 leaves it unchanged.
- R8: irq_o is high when (control bit0 AND status bit0) OR (control bit1 AND status bit1). Clearing an enable masks irq_o but keeps the latched status.
- R9: wake_o is high when control bit7 is set, OR (control bit2 AND status bit0), OR (control bit3 AND status bit1).
- R10: Status bit2 becomes set one clock after wake_o rises. It is not set again while wake_o merely stays high.
- R11: The key register at 0x18 reads back the last 32-bit value written to it.
- R12: Reads of offsets that have no register return zero. Control bits 5 and 8..31 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Masked match interrupt |
| wake_o | output | 1 | Wake / power-on request |

## Verification
The bench wraps both counters across 2^32. A design that misses the wrap, or that borrows on the wrong side, reads back a wrong value in at least one of the two counters. It writes a counter in the same cycle as a tick; a design with the wrong priority shows an off-by-one load, or a down-counter that stops following the tick. It writes a clear while a match is still holding, and clears the wake status while wake_o stays high. A design that lets the clear win, or that latches the wake level instead of its edge, shows a wrong status value. It also checks the software-reset bit against the key register: a design whose software reset reaches the key register loses the stored value.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int NUM_CH     = 2;
  localparam int OFF_UP     = 'h00;
  localparam int OFF_DN     = 'h04;
  localparam int OFF_MATCH0 = 'h08;
  localparam int OFF_CTRL   = 'h10;
  localparam int OFF_STAT   = 'h14;
  localparam int OFF_KEY    = 'h18;
  // control bit positions
  localparam int CB_IRQ0  = 0;
  localparam int CB_WAKE0 = 2;
  localparam int CB_SRST  = 4;
  localparam int CB_HALT  = 6;
  localparam int CB_FORCE = 7;
  localparam logic [7:0] CTRL_MASK = 8'hDF;
endpackage

// File: rtl/sec_rtc_count.sv
module sec_rtc_count #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         halt_i,
  input  logic         soft_i,
  input  logic         up_we_i,
  input  logic         dn_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] up_o,
  output logic [W-1:0] dn_o
);
  logic step;
  assign step = tick_i && !halt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= '0;
      dn_o <= '0;
    end else if (soft_i) begin
      up_o <= '0;
      dn_o <= '0;
    end else begin
      if (up_we_i)   up_o <= wdata_i;
      else if (step) up_o <= up_o + W'(1);
      if (dn_we_i)   dn_o <= wdata_i;
      else if (step) dn_o <= dn_o - W'(1);
    end
  end

  assert_tick_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_i && !soft_i && !up_we_i && !dn_we_i) |=>
      (up_o == $past(up_o) + W'(1)) && (dn_o == $past(dn_o) - W'(1)));
  assert_halt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !soft_i && !up_we_i && !dn_we_i) |=> $stable(up_o) && $stable(dn_o));
  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_we_i && !soft_i) |=> up_o == $past(wdata_i));
  assert_soft_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_i |=> (up_o == '0) && (dn_o == '0));
endmodule

// File: rtl/sec_rtc_chan.sv
module sec_rtc_chan #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         match_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  input  logic [W-1:0] up_i,
  output logic [W-1:0] match_o,
  output logic         stat_o
);
  logic hit;
  assign hit = (up_i == match_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         match_o <= '1;
    else if (match_we_i) match_o <= wdata_i;
  end

  // set wins over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_o <= 1'b0;
    else if (hit)    stat_o <= 1'b1;
    else if (clr_i)  stat_o <= 1'b0;
  end

  assert_hit_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i == match_o) |=> stat_o);
  assert_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (up_i != match_o)) |=> !stat_o);
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [7:0]        ctrl_q;
  logic [DATA_W-1:0] key_q, up_cnt, dn_cnt;
  logic [DATA_W-1:0] match_v [NUM_CH];
  logic [NUM_CH-1:0] stat_match;
  logic              stat_wake, wake_q;
  logic              sel_ctrl, sel_stat, sel_key;

  assign sel_ctrl = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_stat = we_i && (addr_i == ADDR_W'(OFF_STAT));
  assign sel_key  = we_i && (addr_i == ADDR_W'(OFF_KEY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (sel_ctrl) ctrl_q <= wdata_i[7:0] & CTRL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      key_q <= '0;
    else if (sel_key) key_q <= wdata_i;
  end

  sec_rtc_count #(.W(DATA_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .halt_i  (ctrl_q[CB_HALT]),
    .soft_i  (ctrl_q[CB_SRST]),
    .up_we_i (we_i && (addr_i == ADDR_W'(OFF_UP))),
    .dn_we_i (we_i && (addr_i == ADDR_W'(OFF_DN))),
    .wdata_i (wdata_i),
    .up_o    (up_cnt),
    .dn_o    (dn_cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    sec_rtc_chan #(.W(DATA_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .match_we_i (we_i && (addr_i == ADDR_W'(OFF_MATCH0 + 4 * i))),
      .wdata_i    (wdata_i),
      .clr_i      (sel_stat && wdata_i[i]),
      .up_i       (up_cnt),
      .match_o    (match_v[i]),
      .stat_o     (stat_match[i])
    );
  end

  assign irq_o  = |(stat_match & ctrl_q[CB_IRQ0 +: NUM_CH]);
  assign wake_o = ctrl_q[CB_FORCE] | (|(stat_match & ctrl_q[CB_WAKE0 +: NUM_CH]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q    <= 1'b0;
      stat_wake <= 1'b0;
    end else begin
      wake_q <= wake_o;
      if (wake_o && !wake_q)               stat_wake <= 1'b1;
      else if (sel_stat && wdata_i[NUM_CH]) stat_wake <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      OFF_UP:         rdata_o = up_cnt;
      OFF_DN:         rdata_o = dn_cnt;
      OFF_MATCH0:     rdata_o = match_v[0];
      OFF_MATCH0 + 4: rdata_o = match_v[1];
      OFF_CTRL:       rdata_o = DATA_W'(ctrl_q);
      OFF_STAT:       rdata_o = DATA_W'({stat_wake, stat_match});
      OFF_KEY:        rdata_o = key_q;
      default:        rdata_o = '0;
    endcase
  end

  assert_wake_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !wake_q) |=> stat_wake);
  assert_key_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_key |=> $stable(key_q));
  assert_ctrl_gap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ctrl |=> !ctrl_q[5]);
endmodule

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;
  localparam time CLK_PERIOD = 10ns;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wake;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sec_rtc u0 (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
              .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R1 up", 8'h00, 32'h0);
    rd_chk("R1 dn", 8'h04, 32'h0);
    rd_chk("R1 m0", 8'h08, 32'hFFFFFFFF);
    rd_chk("R1 m1", 8'h0C, 32'hFFFFFFFF);
    rd_chk("R1 ctrl", 8'h10, 32'h0);
    rd_chk("R1 stat", 8'h14, 32'h0);
    rd_chk("R1 key", 8'h18, 32'h0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wake", {31'b0, wake}, 0);
  endtask

  task automatic t_count;
    wr(8'h10, 32'h40);
    wr(8'h00, 32'd100);
    wr(8'h04, 32'hFFFFFFFF - 32'd100);
    pulse(3);
    rd_chk("R3 up held", 8'h00, 32'd100);
    rd_chk("R3 dn held", 8'h04, 32'hFFFFFFFF - 32'd100);
    wr(8'h10, 32'h0);
    pulse(3);
    rd_chk("R2 up", 8'h00, 32'd103);
    rd_chk("R2 dn", 8'h04, 32'hFFFFFFFF - 32'd103);
  endtask

  task automatic t_wrap;
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h04, 32'h0);
    pulse(1);
    rd_chk("R2 up wrap", 8'h00, 32'h0);
    rd_chk("R2 dn wrap", 8'h04, 32'hFFFFFFFF);
    wr(8'h14, 32'h7);
    rd_chk("R7 clear", 8'h14, 32'h0);
    // write and tick in the same cycle
    @(negedge clk); we = 1'b1; tick = 1'b1; addr = 8'h00; wdata = 32'd50;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd_chk("R4 up load", 8'h00, 32'd50);
    rd_chk("R4 dn ticks", 8'h04, 32'hFFFFFFFE);
  endtask

  task automatic t_soft;
    wr(8'h18, 32'hB5C13F27);
    wr(8'h10, 32'h10);
    pulse(1);
    rd_chk("R5 up zero", 8'h00, 32'h0);
    rd_chk("R5 dn zero", 8'h04, 32'h0);
    wr(8'h00, 32'd5);
    rd_chk("R5 write ignored", 8'h00, 32'h0);
    rd_chk("R5 key kept", 8'h18, 32'hB5C13F27);
    wr(8'h10, 32'h0);
    rd_chk("R11 key", 8'h18, 32'hB5C13F27);
  endtask

  task automatic t_match;
    wr(8'h10, 32'h01);
    wr(8'h08, 32'd3);
    wr(8'h14, 32'h7);
    pulse(3);
    @(negedge clk);
    rd_chk("R6 st0 set", 8'h14, 32'h1);
    chk("R8 irq", {31'b0, irq}, 1);
    wr(8'h14, 32'h1);
    rd_chk("R6 set beats clear", 8'h14, 32'h1);
    wr(8'h10, 32'h0);
    chk("R8 masked", {31'b0, irq}, 0);
    rd_chk("R8 status kept", 8'h14, 32'h1);
    wr(8'h08, 32'hFFFFFFFF);
    wr(8'h14, 32'h0);
    rd_chk("R7 zero keeps", 8'h14, 32'h1);
    wr(8'h14, 32'h1);
    rd_chk("R7 one clears", 8'h14, 32'h0);
    // channel 1 with irq and wake
    wr(8'h0C, 32'd5);
    wr(8'h10, 32'h0A);
    pulse(2);
    @(negedge clk);
    chk("R8 irq ch1", {31'b0, irq}, 1);
    chk("R9 wake ch1", {31'b0, wake}, 1);
    @(negedge clk);
    rd_chk("R10 wake status", 8'h14, 32'h6);
    wr(8'h0C, 32'hFFFFFFFF);
    wr(8'h14, 32'h7);
    rd_chk("R7 all clear", 8'h14, 32'h0);
    chk("R9 wake low", {31'b0, wake}, 0);
  endtask

  task automatic t_force;
    wr(8'h10, 32'h80);
    chk("R9 force", {31'b0, wake}, 1);
    @(negedge clk);
    rd_chk("R10 edge latch", 8'h14, 32'h4);
    wr(8'h14, 32'h4);
    @(negedge clk);
    rd_chk("R10 no relatch on level", 8'h14, 32'h0);
    wr(8'h10, 32'h0);
  endtask

  task automatic t_map;
    rd_chk("R12 hole 1C", 8'h1C, 32'h0);
    rd_chk("R12 hole 80", 8'h80, 32'h0);
    wr(8'h10, 32'hFFFFFFFF);
    rd_chk("R12 ctrl bits", 8'h10, 32'h000000DF);
    wr(8'h10, 32'h0);
    wr(8'h18, 32'h12345678);
    rd_chk("R11 key rw", 8'h18, 32'h12345678);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_count();
    t_wrap();
    t_soft();
    t_match();
    t_force();
    t_map();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule